// File: doc/BRIEF.md
# Flash Timing Clock Divider

This block turns the system bus clock into a slow timing strobe for nonvolatile memory program and erase operations. Software writes one configuration word that holds a 6-bit divide value and a prescaler enable. With the prescaler off, the strobe repeats every (div + 1) bus cycles. With it on, a fixed divide-by-8 stage sits in front of the (div + 1) counter, so the strobe repeats every 8 × (div + 1) bus cycles. For example, a 20 MHz bus with the prescaler on and div = 12 gives about 192.3 kHz. A 4 MHz bus with the prescaler off and div = 19 gives 200 kHz.

The output is a one-cycle enable pulse in the bus clock domain, not a gated clock. The configuration word can be written only once after reset, and a flag shows that it has been written. A combinational check compares the programmed strobe period, at the bus frequency given by the parameter `BUS_KHZ`, with the legal pulse window of 5 µs to 6.7 µs. That window matches a strobe frequency of 150–200 kHz.

Top module: `flash_tick_div`

## Requirements
- R1: While in reset and right after it, `cfg_done_o` and `tick_o` are 0. The held setting is div = 0 with the prescaler off, so the ratio is 1.
- R2: When `cfg_data_i[6]` = 0, `tick_o` pulses once every (div + 1) bus cycles, where div is `cfg_data_i[5:0]`.
- R3: When `cfg_data_i[6]` = 1, `tick_o` pulses once every 8 × (div + 1) bus cycles.
- R4: With div = 0 and the prescaler off, `tick_o` is high in every cycle after configuration.
- R5: The first write sets `cfg_done_o` from the next cycle onward. Every later write is ignored until reset: the period and `cfg_done_o` stay unchanged.
- R6: `tick_o` stays 0 until the configuration has been written.
- R7: The first pulse comes in cycle N−1, where N is the ratio and cycle 0 is the first cycle in which `cfg_done_o` is 1.
- R8: When N > 1, `tick_o` is never high in two consecutive cycles.
- R9: `period_bad_o` is 1 exactly when N × 10^6 / `BUS_KHZ` ns is below 5000 ns or above 6700 ns, evaluated on the held setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 7 | [6] prescaler enable, [5:0] divide value |
| cfg_done_o | output | 1 | Configuration has been written and is locked |
| tick_o | output | 1 | One-cycle timing strobe at the divided rate |
| period_bad_o | output | 1 | Programmed strobe period lies outside 5–6.7 µs |

## Verification
A write attempt can land in the same cycle as a strobe. In that case the locked counter must not be restarted or re-ratioed. The bench provokes this by waiting for a strobe at a falling edge and raising the write strobe at that same edge with a different setting. It then judges the result by measuring the next three intervals, which must still equal the original ratio, and by confirming that `cfg_done_o` and `period_bad_o` keep their values.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  localparam int unsigned FTD_DIV_W    = 6;
  localparam int unsigned FTD_PRE_LOG2 = 3;

  // total bus cycles per strobe
  function automatic logic [63:0] ftd_ratio(input logic pre8,
                                            input logic [63:0] div,
                                            input int unsigned pre_log2);
    logic [63:0] base;
    base = div + 64'd1;
    return pre8 ? (base << pre_log2) : base;
  endfunction
endpackage

// File: rtl/ftd_cfg_reg.sv
module ftd_cfg_reg #(
  parameter int unsigned CFG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             done_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else if (we_i && !done_q) begin
      cfg_q  <= data_i;
      done_q <= 1'b1;
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;

  // R5
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(cfg_q));
  // R5
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/ftd_prescaler.sv
module ftd_prescaler #(
  parameter int unsigned PRE_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pre8_i,
  output logic step_o
);
  generate
    if (PRE_LOG2 == 0) begin : g_none
      assign step_o = run_i;
    end else begin : g_div
      logic [PRE_LOG2-1:0] pcnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pcnt_q <= '0;
        else if (!run_i)  pcnt_q <= '0;
        else              pcnt_q <= pcnt_q + 1'b1;
      end

      assign step_o = run_i && (!pre8_i || (&pcnt_q));

      // R3
      pre_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pre8_i && step_o) |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/ftd_div_counter.sv
module ftd_div_counter #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && step_i && wrap;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i);
  // R8
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/ftd_period_chk.sv
module ftd_period_chk #(
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned PRE_LOG2 = 3,
  parameter int unsigned BUS_KHZ  = 4000,
  parameter int unsigned MIN_NS   = 5000,
  parameter int unsigned MAX_NS   = 6700
) (
  input  logic             pre8_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bad_o
);
  import ftd_pkg::*;

  localparam logic [63:0] LO_LIM = 64'(MIN_NS) * 64'(BUS_KHZ);
  localparam logic [63:0] HI_LIM = 64'(MAX_NS) * 64'(BUS_KHZ);

  logic [63:0] ratio;
  logic [63:0] scaled;  // period_ns * BUS_KHZ

  always_comb begin
    ratio  = ftd_ratio(pre8_i, 64'(div_i), PRE_LOG2);
    scaled = ratio * 64'd1_000_000;
    bad_o  = (scaled < LO_LIM) || (scaled > HI_LIM);
  end
endmodule

// File: rtl/flash_tick_div.sv
module flash_tick_div #(
  parameter int unsigned DIV_W    = ftd_pkg::FTD_DIV_W,
  parameter int unsigned PRE_LOG2 = ftd_pkg::FTD_PRE_LOG2,
  parameter int unsigned BUS_KHZ  = 4000,
  parameter int unsigned MIN_NS   = 5000,
  parameter int unsigned MAX_NS   = 6700
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DIV_W:0]   cfg_data_i,
  output logic             cfg_done_o,
  output logic             tick_o,
  output logic             period_bad_o
);
  localparam int unsigned CFG_W   = DIV_W + 1;
  localparam int unsigned PRE_BIT = DIV_W;

  logic [CFG_W-1:0] cfg;
  logic             done;
  logic             step;
  logic             pre8;
  logic [DIV_W-1:0] div;

  ftd_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .data_i(cfg_data_i), .cfg_o(cfg), .done_o(done)
  );

  assign pre8 = cfg[PRE_BIT];
  assign div  = cfg[DIV_W-1:0];

  ftd_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(done), .pre8_i(pre8), .step_o(step)
  );

  ftd_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(done), .step_i(step),
    .div_i(div), .tick_o(tick_o)
  );

  ftd_period_chk #(
    .DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2), .BUS_KHZ(BUS_KHZ),
    .MIN_NS(MIN_NS), .MAX_NS(MAX_NS)
  ) u_chk (
    .pre8_i(pre8), .div_i(div), .bad_o(period_bad_o)
  );

  assign cfg_done_o = done;

  // R6
  no_early_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> !tick_o);
  // R9
  bad_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> $stable(period_bad_o));
endmodule

// File: tb/flash_tick_div_tb_top.sv
module flash_tick_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_KHZ    = 4000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [6:0] cfg_data_i = '0;
  logic       cfg_done_o, tick_o, period_bad_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_tick_div #(.BUS_KHZ(BUS_KHZ)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
    .cfg_done_o(cfg_done_o), .tick_o(tick_o), .period_bad_o(period_bad_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input bit pre, input int d);
    return pre ? 8 * (d + 1) : (d + 1);
  endfunction

  function automatic bit bad_of(input int n);
    longint p;
    p = longint'(n) * 1_000_000;
    return (p < 5000 * BUS_KHZ) || (p > 6700 * BUS_KHZ);
  endfunction

  task automatic do_reset();
    cfg_we_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(cfg_done_o == 1'b0, "R1", cfg_done_o, 0);
    check(tick_o == 1'b0, "R1", tick_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic write_cfg(input bit pre, input int d);
    cfg_data_i = {pre, 6'(d)};
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // count cycles until next strobe, checking for back-to-back pulses
  task automatic measure(input int n, input string req);
    int c = 0;
    @(negedge clk_i);
    c = 1;
    if (n > 1) check(tick_o == 1'b0, "R8", tick_o, 0);
    while (!tick_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    check(c == n, req, c, n);
  endtask

  task automatic run_case(input bit pre, input int d, input string req);
    int n = ratio_of(pre, d);
    int c = 0;
    do_reset();
    write_cfg(pre, d);
    check(cfg_done_o == 1'b1, "R5", cfg_done_o, 1);
    while (!tick_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    check(c == n - 1, "R7", c, n - 1);
    for (int k = 0; k < 3; k++) measure(n, req);
    check(period_bad_o == bad_of(n), "R9", period_bad_o, bad_of(n));
  endtask

  task automatic test_reset_idle();
    do_reset();
    check(period_bad_o == bad_of(1), "R1", period_bad_o, bad_of(1));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      check(tick_o == 1'b0, "R6", tick_o, 0);
    end
  endtask

  task automatic test_div0();
    do_reset();
    write_cfg(1'b0, 0);
    for (int k = 0; k < 5; k++) begin
      check(tick_o == 1'b1, "R4", tick_o, 1);
      @(negedge clk_i);
    end
    check(period_bad_o == 1'b1, "R9", period_bad_o, 1);
  endtask

  task automatic test_lock_collision();
    int c = 0;
    run_case(1'b0, 19, "R2");
    while (!tick_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    // rewrite lands in the strobe cycle
    cfg_data_i = {1'b1, 6'd3};
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    c = 1;
    while (!tick_o && c < 5000) begin
      @(negedge clk_i);
      c++;
    end
    check(c == 20, "R5", c, 20);
    for (int k = 0; k < 2; k++) measure(20, "R5");
    check(cfg_done_o == 1'b1, "R5", cfg_done_o, 1);
    check(period_bad_o == 1'b0, "R5", period_bad_o, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset_idle();
    run_case(1'b0, 19, "R2");
    run_case(1'b0, 20, "R2");
    run_case(1'b0, 18, "R2");
    run_case(1'b0, 26, "R2");
    run_case(1'b1, 2, "R3");
    run_case(1'b1, 3, "R3");
    run_case(1'b1, 63, "R3");
    test_div0();
    test_lock_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule